// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher with Per-Field Wildcards

This block decides, once per second, whether the current time of day has reached a programmed alarm time. It takes the current seconds, minutes and hours bytes together with three alarm bytes, and it compares them only in the cycle when the one-second update reports that it has finished. If every field either equals its alarm byte or is masked, the block raises a single-cycle alarm event. That event goes to the interrupt status logic, which handles enabling, flag latching and the interrupt line.

An alarm byte whose two most significant bits are both set is a wildcard and matches any current value. Setting wildcards in different fields sets the alarm rate. Three real bytes give one alarm a day. A wildcard in the hours field gives one alarm an hour. Wildcards in hours and minutes give one alarm a minute. Three wildcards give one alarm per update. Bytes are compared exactly as they are stored, so BCD and binary time formats both work without any conversion.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: While `rst_n` is low, `alarm_evt` is 0. After reset is released, `alarm_evt` stays 0 until an update strobe has been seen.
- R2: An alarm byte whose bits 7 and 6 are not both 1 matches only if it equals the corresponding current time byte in all 8 bits.
- R3: An alarm byte whose bits 7 and 6 are both 1 (any value 0xC0 to 0xFF) matches every current value of its field.
- R4: A byte with only bit 7 set (0x80 to 0xBF), or with only bit 6 set (0x40 to 0x7F), is not a wildcard. It follows R2.
- R5: When `upd_done` is high for one cycle and all three fields match, `alarm_evt` is 1 for exactly one cycle: the cycle after the strobe.
- R6: In a cycle without the strobe, `alarm_evt` does not rise, even when all three fields match and stay matched.
- R7: With real alarm bytes in all three fields, a walk of the time through seconds produces exactly one event per day, at the programmed time.
- R8: With a wildcard in the hours byte only, the alarm fires once every hour, at the programmed minute and second.
- R9: With wildcards in hours and minutes, the alarm fires once per minute. With wildcards in all three bytes, it fires on every update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_done | input | 1 | One-cycle strobe marking the end of the one-second update |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| alarm_evt | output | 1 | One-cycle alarm event to the interrupt status logic |

## Verification
The hardest case to reach from the ports is the daily and hourly behaviour, because matches must be counted across many consecutive seconds rather than checked one at a time. The bench drives a BCD time of day that steps once per strobe. It runs for two hours under an hours wildcard and for a full hour around a daily alarm, and it compares each strobe's result with the time it computed itself. The wildcard decode boundary is covered by sweeping every alarm byte value in each field. Each value is paired with current values that differ in one bit, so that bits 7 and 6 are tested on their own.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam int unsigned FIELD_W    = 8;
   localparam int unsigned NUM_FIELDS = 3;
   localparam int unsigned WILD_BITS  = 2;

   typedef enum logic [1:0] {
      FLD_SEC = 2'd0,
      FLD_MIN = 2'd1,
      FLD_HR  = 2'd2
   } field_e;

   typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/rtc_alarm_field_match.sv
module rtc_alarm_field_match #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned WILD_W = 2
) (
   input  logic [BYTE_W-1:0] cur_byte,
   input  logic [BYTE_W-1:0] alm_byte,
   output logic              is_wild,
   output logic              hit
);
   localparam int unsigned TOP_LSB = BYTE_W - WILD_W;

   if (WILD_W > BYTE_W) begin : g_bad_width
      initial $error("rtc_alarm_field_match: WILD_W exceeds BYTE_W");
   end

   if (WILD_W == 0) begin : g_no_wild
      assign is_wild = 1'b0;
   end else begin : g_wild
      assign is_wild = &alm_byte[BYTE_W-1:TOP_LSB];
   end

   logic exact;
   assign exact = (cur_byte == alm_byte);
   assign hit   = is_wild | exact;
endmodule

// File: rtl/rtc_alarm_combine.sv
module rtc_alarm_combine #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe,
   input  logic [N-1:0] hits,
   output logic         evt
);
   if (N == 0) begin : g_bad_count
      initial $error("rtc_alarm_combine: N must be at least 1");
   end

   logic all_hit;
   assign all_hit = &hits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt <= 1'b0;
      else        evt <= strobe & all_hit;
   end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned BYTE_W = FIELD_W,
   parameter int unsigned WILD_W = WILD_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_done,
   input  logic [BYTE_W-1:0] cur_sec,
   input  logic [BYTE_W-1:0] cur_min,
   input  logic [BYTE_W-1:0] cur_hr,
   input  logic [BYTE_W-1:0] alm_sec,
   input  logic [BYTE_W-1:0] alm_min,
   input  logic [BYTE_W-1:0] alm_hr,
   output logic              alarm_evt
);
   localparam int unsigned NF = NUM_FIELDS;

   if (BYTE_W < 2) begin : g_bad_byte
      initial $error("rtc_alarm_cmp: BYTE_W too small");
   end

   logic [BYTE_W-1:0] cur_v [NF];
   logic [BYTE_W-1:0] alm_v [NF];
   logic [NF-1:0]     hit_v;
   logic [NF-1:0]     wild_v;

   assign cur_v[FLD_SEC] = cur_sec;
   assign cur_v[FLD_MIN] = cur_min;
   assign cur_v[FLD_HR]  = cur_hr;
   assign alm_v[FLD_SEC] = alm_sec;
   assign alm_v[FLD_MIN] = alm_min;
   assign alm_v[FLD_HR]  = alm_hr;

   for (genvar f = 0; f < NF; f++) begin : g_field
      rtc_alarm_field_match #(
         .BYTE_W (BYTE_W),
         .WILD_W (WILD_W)
      ) u_match (
         .cur_byte (cur_v[f]),
         .alm_byte (alm_v[f]),
         .is_wild  (wild_v[f]),
         .hit      (hit_v[f])
      );
   end

   rtc_alarm_combine #(
      .N (NF)
   ) u_combine (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (upd_done),
      .hits   (hit_v),
      .evt    (alarm_evt)
   );
endmodule

// File: rtl/rtc_alarm_cmp_chk.sv
module rtc_alarm_cmp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       upd_done,
   input logic [7:0] cur_sec,
   input logic [7:0] cur_min,
   input logic [7:0] cur_hr,
   input logic [7:0] alm_sec,
   input logic [7:0] alm_min,
   input logic [7:0] alm_hr,
   input logic       alarm_evt
);
   logic all_wild, all_eq, sec_miss;
   assign all_wild = (alm_sec[7:6] == 2'b11) && (alm_min[7:6] == 2'b11) && (alm_hr[7:6] == 2'b11);
   assign all_eq   = (alm_sec == cur_sec) && (alm_min == cur_min) && (alm_hr == cur_hr);
   assign sec_miss = (alm_sec[7:6] != 2'b11) && (alm_sec != cur_sec);

   // R6: an event is always preceded by a strobe
   a_r6_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |-> $past(upd_done));
   // R5: a single strobe gives a single-cycle event
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_evt && !$past(upd_done, 1)) |-> 1'b0);
   // R2: all fields equal at a strobe gives an event
   a_r2_exact_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_done && all_eq) |=> alarm_evt);
   // R2: a real seconds byte that differs blocks the event
   a_r2_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_done && sec_miss) |=> !alarm_evt);
   // R9: three wildcards fire on every strobe
   a_r9_all_wild: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_done && all_wild) |=> alarm_evt);
endmodule

bind rtc_alarm_cmp rtc_alarm_cmp_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .upd_done  (upd_done),
   .cur_sec   (cur_sec),
   .cur_min   (cur_min),
   .cur_hr    (cur_hr),
   .alm_sec   (alm_sec),
   .alm_min   (alm_min),
   .alm_hr    (alm_hr),
   .alarm_evt (alarm_evt)
);

// File: tb/rtc_alarm_cmp_bench.sv
`timescale 1ns/1ps
module rtc_alarm_cmp_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_done = 1'b0;
   logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hr = 8'h00;
   logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
   logic       alarm_evt;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rtc_alarm_cmp u_rtc_alarm_cmp (
      .clk (clk), .rst_n (rst_n), .upd_done (upd_done),
      .cur_sec (cur_sec), .cur_min (cur_min), .cur_hr (cur_hr),
      .alm_sec (alm_sec), .alm_min (alm_min), .alm_hr (alm_hr),
      .alarm_evt (alarm_evt)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: alarm_evt=%0b expected %0b (alm %h:%h:%h cur %h:%h:%h)",
                  req, act, exp, alm_hr, alm_min, alm_sec, cur_hr, cur_min, cur_sec);
      end
   endtask

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic fmatch(input logic [7:0] a, input logic [7:0] c);
      return (a[7] && a[6]) || (a == c);
   endfunction

   // one strobe; the event is expected one cycle after, and gone the cycle after that
   task automatic tick(input string req, input logic exp, output logic got);
      upd_done = 1'b1;
      @(negedge clk);
      upd_done = 1'b0;
      got = alarm_evt;
      check(req, alarm_evt, exp);
      @(negedge clk);
      check("R5", alarm_evt, 1'b0);
   endtask

   task automatic set_time(input int t);
      cur_hr  = bcd(t / 3600);
      cur_min = bcd((t / 60) % 60);
      cur_sec = bcd(t % 60);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end (actual hung, expected done)");
      finish_run();
   end

   initial begin
      logic got;
      int   cnt;
      string tag;
      // R1: reset state
      cur_sec = 8'h12; alm_sec = 8'h12;
      upd_done = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", alarm_evt, 1'b0);
      upd_done = 1'b0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", alarm_evt, 1'b0);

      // R6: sustained match without strobe
      alm_sec = 8'h05; alm_min = 8'h06; alm_hr = 8'h07;
      cur_sec = 8'h05; cur_min = 8'h06; cur_hr = 8'h07;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         check("R6", alarm_evt, 1'b0);
      end
      tick("R5", 1'b1, got);

      // R2 R3 R4: per-field sweep of every alarm byte, others wildcarded
      for (int f = 0; f < 3; f++) begin
         for (int a = 0; a < 256; a++) begin
            for (int k = -1; k < 8; k++) begin
               logic [7:0] c;
               c = (k < 0) ? 8'(a) : (8'(a) ^ (8'h01 << k));
               alm_sec = 8'hFF; alm_min = 8'hC0; alm_hr = 8'hE5;
               cur_sec = 8'h00; cur_min = 8'h00; cur_hr = 8'h00;
               if (f == 0) begin alm_sec = 8'(a); cur_sec = c; end
               if (f == 1) begin alm_min = 8'(a); cur_min = c; end
               if (f == 2) begin alm_hr  = 8'(a); cur_hr  = c; end
               tag = (a >= 8'hC0) ? "R3" : ((a >= 8'h40) ? "R4" : "R2");
               tick(tag, fmatch(8'(a), c), got);
            end
         end
      end

      // R8: hours wildcard over two hours, alarm at mm:ss = 30:15
      alm_hr = 8'hC3; alm_min = 8'h30; alm_sec = 8'h15;
      cnt = 0;
      for (int t = 36000; t < 36000 + 7200; t++) begin
         set_time(t);
         tick("R8", ((t % 3600) == 30*60 + 15), got);
         if (got) cnt++;
      end
      check("R8", (cnt == 2), 1'b1);

      // R7: daily alarm at 13:47:09, walk the hour 13 and part of hour 14
      alm_hr = 8'h13; alm_min = 8'h47; alm_sec = 8'h09;
      cnt = 0;
      for (int t = 13*3600; t < 14*3600 + 600; t++) begin
         set_time(t);
         tick("R7", (t == 13*3600 + 47*60 + 9), got);
         if (got) cnt++;
      end
      check("R7", (cnt == 1), 1'b1);

      // R9: hours and minutes wildcard, seconds 42, over three minutes
      alm_hr = 8'hFF; alm_min = 8'hD9; alm_sec = 8'h42;
      cnt = 0;
      for (int t = 0; t < 180; t++) begin
         set_time(23*3600 + 58*60 + t);
         tick("R9", ((t % 60) == 42), got);
         if (got) cnt++;
      end
      check("R9", (cnt == 3), 1'b1);

      // R9: all wildcards, every update
      alm_hr = 8'hC0; alm_min = 8'hFF; alm_sec = 8'hC1;
      for (int t = 0; t < 70; t++) begin
         set_time(t * 37);
         tick("R9", 1'b1, got);
      end

      // R5: back-to-back strobes give back-to-back events
      upd_done = 1'b1;
      @(negedge clk);
      check("R5", alarm_evt, 1'b1);
      @(negedge clk);
      check("R5", alarm_evt, 1'b1);
      upd_done = 1'b0;
      @(negedge clk);
      check("R5", alarm_evt, 1'b0);

      finish_run();
   end
endmodule